// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors held in word-addressed memory. For each descriptor it first reads the control word and checks the hardware-ownership flag. If the flag is set, it reads the remaining words and starts one transfer on a data mover through a start/done handshake. The start carries the source and destination addresses, the byte count, the burst hints and the control flags. When the mover reports completion, the sequencer writes one word back into the descriptor. That word holds the byte count actually moved, a status byte built from the mover's error flags and end-of-packet indication, and the control byte with ownership cleared. The sequencer then follows the link pointer to the next descriptor.

Software builds a chain and hands each descriptor to hardware by setting its ownership flag. It then pulses `go` while `run` is high. The chain ends on a descriptor that is not owned, on an error when stop-on-error is enabled, or at a descriptor boundary once `run` has been lowered. With polling enabled, a descriptor that is not owned is re-read at a programmed interval until software hands it over or lowers `run`. The mover's data path is outside this block.

Descriptor layout, in words from the descriptor base: +0 source address, +1 destination address, +2 link pointer (word address of the next descriptor), +3 {burst hints[31:16], byte count[15:0]}, +4 {control byte[31:24], status byte[23:16], actual count[15:0]}. Control byte: bit 7 owned by hardware, bit 0 append end-of-packet, bit 1 fixed source address, bit 2 fixed destination address (start-of-packet when the destination is a stream), bits 6:3 stream channel. Status byte: bits 6:0 mover error flags (CRC, parity, overflow, sync, unexpected end, missing end, missing start), bit 7 end-of-packet seen.

Top module: `desc_chain_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `mv_start`, `mem_rd`, `mem_wr`, `eop_evt` and `chain_done` are all low.
- R2: Each descriptor visit begins with a read of word +4 only. If bit 31 of that word (ownership) is clear and polling is off, the sequencer makes no further read, does not pulse `mv_start`, and pulses `chain_done`.
- R3: For an owned descriptor, `mv_start` pulses for exactly one cycle. While it is high, `mv_src`, `mv_dst`, `mv_len`, `mv_burst` and `mv_flags` equal words +0, +1, +3[15:0], +3[31:16] and the control byte's bits 6:0.
- R4: After `mv_done`, word +4 is written once with {control byte with bit 7 cleared, {mv_eop, mv_err[6:0]}, mv_actual}.
- R5: A byte count of zero is passed to the mover unchanged, and the mover's reported count is written back.
- R6: After a descriptor completes and the chain continues, the next visit reads from the address held in word +2.
- R7: With `stop_on_err` high, a nonzero `mv_err` ends the chain after that descriptor's write-back, and the next descriptor is not read. With it low, the chain continues.
- R8: Lowering `run` during a transfer lets that descriptor finish and write back. The chain then ends without reading the next descriptor.
- R9: With `poll_en` high, a descriptor that is not owned is re-read, with consecutive ownership reads exactly `poll_period`+1 cycles apart when read data returns at the next edge. Once it is owned, it is processed normally.
- R10: Lowering `run` while waiting between polls ends the chain with a `chain_done` pulse.
- R11: `eop_evt` pulses once for each completed descriptor whose mover reported end-of-packet. `chain_done` pulses once per chain. `busy` is high from the first fetch until the `chain_done` cycle, where it is low.
- R12: `go` is ignored while `run` is low: no read is issued and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken when idle and run is high |
| run | input | 1 | Run enable, checked at descriptor boundaries |
| stop_on_err | input | 1 | End the chain after a descriptor that reported an error |
| poll_en | input | 1 | Re-read a descriptor that is not owned instead of stopping |
| poll_period | input | PW | Poll wait in cycles |
| head_ptr | input | AW | Word address of the first descriptor |
| mem_rd | output | 1 | Memory read request (one cycle) |
| mem_wr | output | 1 | Memory write strobe (one cycle) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | Mover start pulse |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_len | output | 16 | Byte count, zero means until end-of-packet |
| mv_flags | output | 7 | Control byte bits 6:0 |
| mv_burst | output | 16 | Burst hints |
| mv_done | input | 1 | Mover completion pulse |
| mv_actual | input | 16 | Bytes actually moved |
| mv_err | input | 7 | Mover error flags |
| mv_eop | input | 1 | Transfer ended on end-of-packet |
| busy | output | 1 | Chain in progress |
| eop_evt | output | 1 | Descriptor finished with end-of-packet |
| chain_done | output | 1 | Chain stopped |

## Verification
The bench feeds single descriptors with extreme and zero byte counts, all-ones and mixed control bytes, and several error and end-of-packet patterns. A design that packed the write-back word wrongly, or that left the ownership flag set, shows a mismatched word +4 in memory. Chains placed at scattered addresses expose a sequencer that steps through memory instead of following the link word. Stop-on-error and a mid-transfer `run` drop are checked by confirming that the next descriptor keeps its ownership flag and is never started. A fetch that runs on past a descriptor that is not owned would show up as extra reads or an extra start. Polling is timed between successive ownership reads, so an off-by-one wait counter shows a wrong spacing, and a poll loop that ignores `run` never reaches `chain_done`.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // word offsets inside one descriptor
  localparam int DESC_WORDS = 5;
  localparam int FLD_SRC    = 0;
  localparam int FLD_DST    = 1;
  localparam int FLD_LINK   = 2;
  localparam int FLD_SIZE   = 3;
  localparam int FLD_CTL    = 4;
  // control word: byte [31:24], ownership at bit 31
  localparam int OWN_BIT    = 31;
  localparam int FLAG_W     = 7;
  localparam int ERR_W      = 7;
  localparam int CNT_W      = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_RETIRE,
    ST_POLL
  } seq_state_t;
endpackage

// File: rtl/dcs_desc_regs.sv
module dcs_desc_regs
  import dcs_pkg::*;
(
  input  logic                         clk,
  input  logic                         cap_en,
  input  logic [2:0]                   cap_slot,
  input  logic [31:0]                  cap_data,
  output logic [FLD_SIZE:0][31:0]      body_q,
  output logic [7:0]                   ctl_q
);
  // one register per body word, selected by slot number
  for (genvar g = 0; g <= FLD_SIZE; g++) begin : g_body
    always_ff @(posedge clk) begin
      if (cap_en && cap_slot == 3'(g))
        body_q[g] <= cap_data;
    end
  end

  // only the control byte of word +4 is kept
  always_ff @(posedge clk) begin
    if (cap_en && cap_slot == 3'(FLD_CTL))
      ctl_q <= cap_data[31:24];
  end
endmodule

// File: rtl/dcs_poll_timer.sv
module dcs_poll_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] period,
  input  logic          active,
  output logic          expire
);
  localparam logic [PW-1:0] ONE = PW'(1);
  logic [PW-1:0] cnt_q;

  assign expire = active && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= period;
    else if (active && !expire)
      cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/dcs_retire_pack.sv
module dcs_retire_pack
  import dcs_pkg::*;
(
  input  logic [7:0]       ctl_byte,
  input  logic [CNT_W-1:0] actual,
  input  logic [ERR_W-1:0] err,
  input  logic             eop,
  output logic [31:0]      wb_word,
  output logic             err_any
);
  logic [7:0] status;
  logic [7:0] ctl_released;

  always_comb begin
    status       = {eop, err};
    ctl_released = ctl_byte;
    ctl_released[OWN_BIT-24] = 1'b0;
    wb_word      = {ctl_released, status, actual};
    err_any      = |err;
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                run,
  input  logic                stop_on_err,
  input  logic                poll_en,
  input  logic [PW-1:0]       poll_period,
  input  logic [AW-1:0]       head_ptr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata,
  output logic                mv_start,
  output logic [31:0]         mv_src,
  output logic [31:0]         mv_dst,
  output logic [CNT_W-1:0]    mv_len,
  output logic [FLAG_W-1:0]   mv_flags,
  output logic [15:0]         mv_burst,
  input  logic                mv_done,
  input  logic [CNT_W-1:0]    mv_actual,
  input  logic [ERR_W-1:0]    mv_err,
  input  logic                mv_eop,
  output logic                busy,
  output logic                eop_evt,
  output logic                chain_done
);
  localparam logic [2:0]    LAST_K  = 3'(DESC_WORDS - 1);
  localparam logic [AW-1:0] CTL_OFS = AW'(FLD_CTL);

  seq_state_t    state;
  logic [AW-1:0] ptr;
  logic [2:0]    k;
  logic          halt_err;

  logic [FLD_SIZE:0][31:0] body;
  logic [7:0]    ctl_byte;
  logic [2:0]    slot;
  logic          cap_en;
  logic          not_owned;
  logic          poll_arm;
  logic          poll_expire;
  logic [31:0]   wb_word;
  logic          err_any;
  logic [AW-1:0] link_ptr;

  // visit order: control word first, then words +0..+3
  assign slot      = (k == 3'd0) ? 3'(FLD_CTL) : k - 3'd1;
  assign cap_en    = (state == ST_FETCH) && mem_rvalid;
  assign not_owned = cap_en && (k == 3'd0) && !mem_rdata[OWN_BIT];
  assign poll_arm  = not_owned && poll_en && run;
  assign link_ptr  = AW'(body[FLD_LINK]);

  dcs_desc_regs u_regs (
    .clk      (clk),
    .cap_en   (cap_en),
    .cap_slot (slot),
    .cap_data (mem_rdata),
    .body_q   (body),
    .ctl_q    (ctl_byte)
  );

  dcs_poll_timer #(.PW(PW)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .load   (poll_arm),
    .period (poll_period),
    .active (state == ST_POLL),
    .expire (poll_expire)
  );

  dcs_retire_pack u_pack (
    .ctl_byte (ctl_byte),
    .actual   (mv_actual),
    .err      (mv_err),
    .eop      (mv_eop),
    .wb_word  (wb_word),
    .err_any  (err_any)
  );

  assign mv_src   = body[FLD_SRC];
  assign mv_dst   = body[FLD_DST];
  assign mv_len   = body[FLD_SIZE][CNT_W-1:0];
  assign mv_burst = body[FLD_SIZE][31:16];
  assign mv_flags = ctl_byte[FLAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      k          <= '0;
      halt_err   <= 1'b0;
      busy       <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mv_start   <= 1'b0;
      eop_evt    <= 1'b0;
      chain_done <= 1'b0;
    end else begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mv_start   <= 1'b0;
      eop_evt    <= 1'b0;
      chain_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go && run) begin
            ptr      <= head_ptr;
            k        <= 3'd0;
            mem_rd   <= 1'b1;
            mem_addr <= head_ptr + CTL_OFS;
            busy     <= 1'b1;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            if (not_owned) begin
              if (poll_arm) begin
                state <= ST_POLL;
              end else begin
                busy       <= 1'b0;
                chain_done <= 1'b1;
                state      <= ST_IDLE;
              end
            end else if (k == LAST_K) begin
              mv_start <= 1'b1;
              state    <= ST_MOVE;
            end else begin
              k        <= k + 3'd1;
              mem_rd   <= 1'b1;
              mem_addr <= ptr + AW'(k);
            end
          end
        end
        ST_MOVE: begin
          if (mv_done) begin
            mem_wr    <= 1'b1;
            mem_addr  <= ptr + CTL_OFS;
            mem_wdata <= wb_word;
            eop_evt   <= mv_eop;
            halt_err  <= stop_on_err && err_any;
            state     <= ST_RETIRE;
          end
        end
        ST_RETIRE: begin
          if (halt_err || !run) begin
            busy       <= 1'b0;
            chain_done <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            ptr      <= link_ptr;
            k        <= 3'd0;
            mem_rd   <= 1'b1;
            mem_addr <= link_ptr + CTL_OFS;
            state    <= ST_FETCH;
          end
        end
        ST_POLL: begin
          if (!run) begin
            busy       <= 1'b0;
            chain_done <= 1'b1;
            state      <= ST_IDLE;
          end else if (poll_expire) begin
            k        <= 3'd0;
            mem_rd   <= 1'b1;
            mem_addr <= ptr + CTL_OFS;
            state    <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mv_start,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_wdata,
  input logic        chain_done
);
  // R3: a start is a single-cycle pulse inside a busy chain
  a_r3_start_in_chain: assert property (@(posedge clk) disable iff (rst)
    mv_start |-> busy);
  a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
    mv_start |=> !mv_start);
  // R4: every write-back releases ownership
  a_r4_wb_released: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !mem_wdata[31]);
  // R2: reads and writes never share a cycle
  a_r2_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R11: busy and chain_done agree at the stop
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    chain_done |-> !busy);
  a_r11_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> chain_done);
endmodule

bind desc_chain_seq dcs_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mv_start   (mv_start),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_wdata  (mem_wdata),
  .chain_done (chain_done)
);

// File: tb/sim_desc_chain_seq.sv
module sim_desc_chain_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic go = 0, run = 0, stop_on_err = 0, poll_en = 0;
  logic [11:0] poll_period = '0;
  logic [31:0] head_ptr = '0;
  logic mem_rd, mem_wr, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic mv_start, mv_done = 0, mv_eop = 0;
  logic [31:0] mv_src, mv_dst;
  logic [15:0] mv_len, mv_burst, mv_actual = '0;
  logic [6:0] mv_flags, mv_err = '0;
  logic busy, eop_evt, chain_done;

  desc_chain_seq u0 (.*);

  logic [31:0] mem [0:255];
  logic [15:0] rsp_act [0:3];
  logic [6:0]  rsp_err [0:3];
  logic        rsp_eop [0:3];
  int mv_lat = 3;
  int rsp_base = 0;
  int watch_addr = 0;

  int cyc = 0, mv_cnt = 0;
  int n_rd = 0, n_wr = 0, n_start = 0, n_eop = 0, n_done = 0;
  int n_watch = 0, last_watch = 0, watch_gap = 0;
  logic [31:0] cap_src, cap_dst;
  logic [15:0] cap_len, cap_burst;
  logic [6:0]  cap_flags;

  int n_chk = 0, n_err = 0;

  // memory and mover models, acting between edges
  always @(negedge clk) begin
    int ri;
    cyc++;
    mem_rvalid = mem_rd;
    if (mem_rd) begin
      mem_rdata = mem[mem_addr[7:0]];
      n_rd++;
      if (int'(mem_addr[7:0]) == watch_addr) begin
        n_watch++;
        watch_gap  = cyc - last_watch;
        last_watch = cyc;
      end
    end
    if (mem_wr) begin
      mem[mem_addr[7:0]] = mem_wdata;
      n_wr++;
    end
    mv_done = 1'b0;
    if (mv_start) begin
      n_start++;
      cap_src = mv_src; cap_dst = mv_dst; cap_len = mv_len;
      cap_burst = mv_burst; cap_flags = mv_flags;
      mv_cnt = mv_lat;
    end else if (mv_cnt > 0) begin
      mv_cnt--;
      if (mv_cnt == 0) begin
        ri = n_start - rsp_base - 1;
        if (ri > 3) ri = 3;
        if (ri < 0) ri = 0;
        mv_done   = 1'b1;
        mv_actual = rsp_act[ri];
        mv_err    = rsp_err[ri];
        mv_eop    = rsp_eop[ri];
      end
    end
    if (eop_evt) n_eop++;
    if (chain_done) n_done++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic clr_mem;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] src, input logic [31:0] dst,
                          input int nxt, input logic [15:0] len, input logic [6:0] fl,
                          input logic own);
    mem[base]     = src;
    mem[base + 1] = dst;
    mem[base + 2] = nxt;
    mem[base + 3] = {16'hA5C3, len};
    mem[base + 4] = {own, fl, 8'h00, 16'h0000};
  endtask

  task automatic set_rsp(input int i, input logic [15:0] a, input logic [6:0] e, input logic p);
    rsp_act[i] = a; rsp_err[i] = e; rsp_eop[i] = p;
  endtask

  task automatic kick(input logic [31:0] head);
    rsp_base = n_start;
    head_ptr = head;
    go = 1'b1;
    tick(1);
    go = 1'b0;
  endtask

  task automatic wait_done(input int base_done);
    int t = 0;
    while (n_done == base_done && t < 3000) begin
      tick(1);
      t++;
    end
    tick(2);
  endtask

  // vector fields: len[46:31] flags[30:24] actual[23:8] err[7:1] eop[0]
  localparam int NV = 6;
  localparam logic [46:0] VEC [NV] = '{
    {16'h0040, 7'h01, 16'h0040, 7'h00, 1'b0},
    {16'h0000, 7'h04, 16'h0123, 7'h00, 1'b1},
    {16'h0010, 7'h7F, 16'h0008, 7'h10, 1'b1},
    {16'hFFFF, 7'h2A, 16'hFFFF, 7'h00, 1'b0},
    {16'h0001, 7'h02, 16'h0000, 7'h41, 1'b0},
    {16'h0200, 7'h58, 16'h0200, 7'h00, 1'b1}
  };

  initial begin
    int b_start, b_done, b_eop, b_rd;
    clr_mem();
    for (int i = 0; i < 4; i++) set_rsp(i, 16'h0, 7'h0, 1'b0);
    tick(2);
    // R1: quiet during reset
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 strobes in reset", {27'b0, mv_start, mem_rd, mem_wr, eop_evt, chain_done}, 32'd0);
    rst = 1'b0;
    tick(1);
    chk("R1 after reset", {26'b0, busy, mv_start, mem_rd, mem_wr, eop_evt, chain_done}, 32'd0);
    run = 1'b1;

    // table walk: single owned descriptor followed by one that is not owned
    for (int v = 0; v < NV; v++) begin
      logic [15:0] len, act;
      logic [6:0]  fl, er;
      logic        ep;
      {len, fl, act, er, ep} = VEC[v];
      clr_mem();
      put_desc(8, 32'h1000 + v, 32'h2000 + v, 40, len, fl, 1'b1);
      set_rsp(0, act, er, ep);
      b_start = n_start; b_done = n_done; b_eop = n_eop;
      kick(8);
      wait_done(b_done);
      chk("R3 one start", n_start - b_start, 1);
      chk("R3 src", cap_src, 32'h1000 + v);
      chk("R3 dst", cap_dst, 32'h2000 + v);
      chk("R3 flags", {25'b0, cap_flags}, {25'b0, fl});
      chk("R3 burst", {16'b0, cap_burst}, 32'h0000A5C3);
      chk("R5 length passed through", {16'b0, cap_len}, {16'b0, len});
      chk("R4 write-back word", mem[12], {1'b0, fl, ep, er, act});
      chk("R11 eop events", n_eop - b_eop, {31'b0, ep});
      chk("R11 one chain_done", n_done - b_done, 1);
      chk("R11 idle after stop", {31'b0, busy}, 32'd0);
    end

    // R2: head not owned, polling off
    clr_mem();
    put_desc(16, 32'h5, 32'h6, 40, 16'h8, 7'h7F, 1'b0);
    b_start = n_start; b_done = n_done; b_rd = n_rd;
    kick(16);
    wait_done(b_done);
    chk("R2 no start", n_start - b_start, 0);
    chk("R2 single read", n_rd - b_rd, 1);
    chk("R2 chain_done", n_done - b_done, 1);

    // R6: chain at scattered addresses 60 -> 100 -> 20 -> 140 (not owned)
    clr_mem();
    put_desc(60, 32'hA0, 32'hB0, 100, 16'h10, 7'h00, 1'b1);
    put_desc(100, 32'hA1, 32'hB1, 20, 16'h20, 7'h00, 1'b1);
    put_desc(20, 32'hA2, 32'hB2, 140, 16'h30, 7'h00, 1'b1);
    for (int i = 0; i < 4; i++) set_rsp(i, 16'h0011, 7'h0, 1'b0);
    b_start = n_start; b_done = n_done; b_rd = n_rd;
    kick(60);
    wait_done(b_done);
    chk("R6 three starts", n_start - b_start, 3);
    chk("R6 last src", cap_src, 32'hA2);
    chk("R6 reads", n_rd - b_rd, 16);
    chk("R6 wb 2nd", mem[104], {8'h00, 8'h00, 16'h0011});
    chk("R6 wb 3rd", mem[24], {8'h00, 8'h00, 16'h0011});

    // R7: stop on error
    clr_mem();
    put_desc(60, 32'hC0, 32'hD0, 100, 16'h4, 7'h00, 1'b1);
    put_desc(100, 32'hC1, 32'hD1, 140, 16'h4, 7'h00, 1'b1);
    set_rsp(0, 16'h0002, 7'h01, 1'b0);
    set_rsp(1, 16'h0004, 7'h00, 1'b0);
    stop_on_err = 1'b1;
    b_start = n_start; b_done = n_done;
    kick(60);
    wait_done(b_done);
    chk("R7 halted after error", n_start - b_start, 1);
    chk("R7 error written back", mem[64], {8'h00, 8'h01, 16'h0002});
    chk("R7 next untouched", mem[104], {8'h80, 24'h0});
    clr_mem();
    put_desc(60, 32'hC0, 32'hD0, 100, 16'h4, 7'h00, 1'b1);
    put_desc(100, 32'hC1, 32'hD1, 140, 16'h4, 7'h00, 1'b1);
    stop_on_err = 1'b0;
    b_start = n_start; b_done = n_done;
    kick(60);
    wait_done(b_done);
    chk("R7 continues without stop_on_err", n_start - b_start, 2);

    // R8: run lowered during a long transfer
    clr_mem();
    put_desc(60, 32'hE0, 32'hF0, 100, 16'h4, 7'h00, 1'b1);
    put_desc(100, 32'hE1, 32'hF1, 140, 16'h4, 7'h00, 1'b1);
    set_rsp(0, 16'h0003, 7'h00, 1'b1);
    mv_lat = 30;
    b_start = n_start; b_done = n_done; b_rd = n_rd; b_eop = n_eop;
    kick(60);
    while (n_start == b_start) tick(1);
    run = 1'b0;
    tick(3);
    chk("R11 busy during transfer", {31'b0, busy}, 32'd1);
    wait_done(b_done);
    chk("R8 single start", n_start - b_start, 1);
    chk("R8 current written back", mem[64], {8'h00, 8'h80, 16'h0003});
    chk("R8 next not read", n_rd - b_rd, 5);
    chk("R8 next still owned", mem[104], {8'h80, 24'h0});
    chk("R11 eop event", n_eop - b_eop, 1);
    mv_lat = 3;

    // R12: go ignored while run is low
    b_rd = n_rd;
    kick(60);
    tick(10);
    chk("R12 no read", n_rd - b_rd, 0);
    chk("R12 not busy", {31'b0, busy}, 32'd0);

    // R9 / R10: polling
    run = 1'b1;
    clr_mem();
    put_desc(60, 32'h77, 32'h88, 100, 16'h9, 7'h00, 1'b0);
    set_rsp(0, 16'h0009, 7'h00, 1'b0);
    poll_en = 1'b1;
    poll_period = 12'd5;
    watch_addr = 64;
    n_watch = 0;
    b_start = n_start; b_done = n_done;
    kick(60);
    begin
      int t = 0;
      while (n_watch < 3 && t < 500) begin tick(1); t++; end
    end
    chk("R9 poll spacing", watch_gap, 6);
    chk("R9 still polling", n_done - b_done, 0);
    mem[64] = {8'h80, 24'h0};
    begin
      int t = 0;
      while (n_start == b_start && t < 500) begin tick(1); t++; end
    end
    chk("R9 start after handover", n_start - b_start, 1);
    chk("R9 src", cap_src, 32'h77);
    watch_addr = 104;
    n_watch = 0;
    begin
      int t = 0;
      while (n_watch < 2 && t < 500) begin tick(1); t++; end
    end
    chk("R9 polls next descriptor", {31'b0, n_watch >= 2}, 32'd1);
    run = 1'b0;
    wait_done(b_done);
    chk("R10 chain_done on run drop", n_done - b_done, 1);
    chk("R10 idle", {31'b0, busy}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule